// File: doc/BRIEF.md
# Programmable Square Wave Channel

One channel of a counter array that produces a square wave with a programmable frequency. A 16-bit timebase advances on each tick of a clock-enable input. The channel keeps an 8-bit compare byte and an 8-bit half-period byte. On every tick it compares its compare byte with the low byte of the timebase. When the two match, the output pin flips and the compare byte moves forward by the half-period. Because each channel re-arms its own compare point, several channels can share one free-running timebase and still run at different frequencies.

The output toggles once every half-period ticks, so the wave has a frequency of f_tick / (2 * half). A half-period of 0 counts as 256. A separate match flag can report when the full 16-bit timebase equals the pair {half-period, compare}. Software writes the registers through a write strobe, a 2-bit address and a data byte. Writing the compare byte first disarms the comparator, and writing the half-period byte arms it again, so a two-byte update never runs half-applied.

Top module: `sqw_chan`

## Requirements
- R1: While reset is asserted, tog_o and flag_o are 0 and the comparator enable is 0.
- R2: The timebase starts at 0 after reset and increments by one (mod 2^16) on each clock where tick_i is 1. It holds when tick_i is 0.
- R3: On a tick, the compare byte is compared with bits [7:0] of the timebase only. A match occurs whenever the low byte equals the compare byte, whatever the high byte holds.
- R4: A match while the square-wave mode is active flips tog_o at that clock edge and sets the compare byte to (compare + half) mod 256. Consecutive flips are therefore exactly half ticks apart.
- R5: A half-period value of 0x00 gives 256 ticks between flips.
- R6: The square-wave mode is active only when control bits cmp_en (bit 0), tog_en (bit 1) and pwm_en (bit 2) are all 1. Otherwise tog_o holds its level and the compare byte does not advance.
- R7: A write to address 1 loads the compare byte and clears cmp_en. A write to address 2 loads the half-period byte and sets cmp_en.
- R8: When control bit mat_en (bit 3) and cmp_en are 1 and, on a tick, the 16-bit timebase equals {half, compare}, flag_o is 1 from the following clock. With mat_en at 0, no such match sets it.
- R9: flag_o stays 1 until a write to address 0 with data bit 4 at 0. Writing bit 4 as 1 leaves it unchanged.
- R10: A write to address 0 loads control bits [3:0]. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase clock enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 compare, 2 half-period, 3 unused |
| wdata_i | input | 8 | Write data |
| tog_o | output | 1 | Square-wave output level |
| flag_o | output | 1 | Sticky 16-bit match flag |

## Verification
The bench programs half-periods of 1, 2, 3, 7, 0x80, 0xFF and 0x00. For each it measures several flip-to-flip intervals and checks the timebase low byte at the first flip. A design that treated 0x00 as zero, compared all 16 bits, or reloaded the compare byte wrongly would show an interval of the wrong length or a first flip at the wrong phase. A second group of tests does four things: it drops a mode bit and re-enables it, it writes only the compare byte, it gates the tick on alternate cycles, and it tests the flag. These catch a compare byte that drifts while idle, a comparator that stays armed during a half-finished update, a timebase that ignores the enable, and a flag that fires early, fires without mat_en, or clears itself.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CMP  = 2'd1,
    REG_HALF = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic mat_en;
    logic pwm_en;
    logic tog_en;
    logic cmp_en;
  } ctrl_t;

  localparam int CTRL_W   = 4;
  localparam int FLAG_BIT = 4;
endpackage

// File: rtl/sqw_timebase.sv
module sqw_timebase #(
  parameter int TB_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [TB_W-1:0] tb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tb_o <= '0;
    else if (tick_i) tb_o <= tb_o + TB_W'(1);
  end
endmodule

// File: rtl/sqw_regs.sv
module sqw_regs
  import sqw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          adv_i,
  input  logic [DW-1:0] adv_val_i,
  input  logic          flag_set_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] cmp_o,
  output logic [DW-1:0] half_o,
  output logic          flag_o
);
  logic wr_ctrl, wr_cmp, wr_half;

  assign wr_ctrl = wr_i && (reg_addr_e'(addr_i) == REG_CTRL);
  assign wr_cmp  = wr_i && (reg_addr_e'(addr_i) == REG_CMP);
  assign wr_half = wr_i && (reg_addr_e'(addr_i) == REG_HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      cmp_o  <= '0;
      half_o <= '0;
    end else begin
      if (wr_ctrl) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      // split 16-bit update: low byte disarms, high byte re-arms
      if (wr_cmp) begin
        cmp_o         <= wdata_i;
        ctrl_o.cmp_en <= 1'b0;
      end else if (adv_i) begin
        cmp_o <= adv_val_i;
      end
      if (wr_half) begin
        half_o        <= wdata_i;
        ctrl_o.cmp_en <= 1'b1;
      end
    end
  end

  // set wins over a same-cycle clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          flag_o <= 1'b0;
    else if (flag_set_i)                  flag_o <= 1'b1;
    else if (wr_ctrl && !wdata_i[FLAG_BIT]) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sqw_toggle.sv
module sqw_toggle
  import sqw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [2*DW-1:0] tb_i,
  input  ctrl_t           ctrl_i,
  input  logic [DW-1:0]   cmp_i,
  input  logic [DW-1:0]   half_i,
  output logic            tog_o,
  output logic            adv_o,
  output logic [DW-1:0]   adv_val_o,
  output logic            flag_set_o
);
  logic mode_on, lo_hit, full_hit;

  assign mode_on   = ctrl_i.cmp_en && ctrl_i.tog_en && ctrl_i.pwm_en;
  assign lo_hit    = (tb_i[DW-1:0] == cmp_i);
  assign full_hit  = (tb_i == {half_i, cmp_i});
  assign adv_o     = tick_i && mode_on && lo_hit;
  assign adv_val_o = cmp_i + half_i; // wraps, so 0 steps a full 2^DW
  assign flag_set_o = tick_i && ctrl_i.mat_en && ctrl_i.cmp_en && full_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tog_o <= 1'b0;
    else if (adv_o) tog_o <= ~tog_o;
  end
endmodule

// File: rtl/sqw_chan.sv
module sqw_chan
  import sqw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          tog_o,
  output logic          flag_o
);
  localparam int TB_W = 2 * DW;

  logic [TB_W-1:0] tb_q;
  ctrl_t           ctrl_q;
  logic [DW-1:0]   cmp_q, half_q, adv_val;
  logic            adv, flag_set;

  sqw_timebase #(.TB_W(TB_W)) i_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .tb_o   (tb_q)
  );

  sqw_regs #(.DW(DW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .adv_i      (adv),
    .adv_val_i  (adv_val),
    .flag_set_i (flag_set),
    .ctrl_o     (ctrl_q),
    .cmp_o      (cmp_q),
    .half_o     (half_q),
    .flag_o     (flag_o)
  );

  sqw_toggle #(.DW(DW)) i_tog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .tb_i       (tb_q),
    .ctrl_i     (ctrl_q),
    .cmp_i      (cmp_q),
    .half_i     (half_q),
    .tog_o      (tog_o),
    .adv_o      (adv),
    .adv_val_o  (adv_val),
    .flag_set_o (flag_set)
  );
endmodule

// File: rtl/sqw_chan_chk.sv
module sqw_chan_chk
  import sqw_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            wr_i,
  input logic [1:0]      addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic            tog_o,
  input logic            flag_o,
  input logic [2*DW-1:0] tb_i,
  input ctrl_t           ctrl_i,
  input logic [DW-1:0]   cmp_i,
  input logic [DW-1:0]   half_i
);
  localparam int TB_W = 2 * DW;

  logic mode, hit, wcmp, whalf, wclr;
  assign mode  = ctrl_i.cmp_en & ctrl_i.tog_en & ctrl_i.pwm_en;
  assign hit   = tick_i && mode && (tb_i[DW-1:0] == cmp_i);
  assign wcmp  = wr_i && (addr_i == 2'd1);
  assign whalf = wr_i && (addr_i == 2'd2);
  assign wclr  = wr_i && (addr_i == 2'd0) && !wdata_i[FLAG_BIT];

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!tog_o && !flag_o && !ctrl_i.cmp_en));

  a_r2_tb_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> tb_i == ($past(tb_i) + TB_W'(1)));

  a_r2_tb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tb_i));

  a_r4_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> tog_o != $past(tog_o));

  a_r4_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wcmp) |=> cmp_i == $past(cmp_i + half_i));

  a_r6_hold_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |=> $stable(tog_o));

  a_r6_hold_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode && !wcmp) |=> $stable(cmp_i));

  a_r7_cmp_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcmp |=> (!ctrl_i.cmp_en && cmp_i == $past(wdata_i)));

  a_r7_half_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    whalf |=> (ctrl_i.cmp_en && half_i == $past(wdata_i)));

  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ctrl_i.mat_en && ctrl_i.cmp_en && tb_i == {half_i, cmp_i}) |=> flag_o);

  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !wclr) |=> flag_o);
endmodule

bind sqw_chan sqw_chan_chk #(.DW(DW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tog_o   (tog_o),
  .flag_o  (flag_o),
  .tb_i    (tb_q),
  .ctrl_i  (ctrl_q),
  .cmp_i   (cmp_q),
  .half_i  (half_q)
);

// File: tb/test_sqw_chan.sv
`timescale 1ns/1ps
module test_sqw_chan;
  localparam int WD_CYCLES = 150000;

  typedef struct packed {
    logic [7:0] half;
    logic [7:0] lo;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{half: 8'h01, lo: 8'h10},
    '{half: 8'h02, lo: 8'h33},
    '{half: 8'h03, lo: 8'hF0},
    '{half: 8'h07, lo: 8'h00},
    '{half: 8'h80, lo: 8'h55},
    '{half: 8'hFF, lo: 8'h01},
    '{half: 8'h00, lo: 8'hA0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic       tog_o, flag_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit div2 = 1'b0;
  bit done = 1'b0;
  logic [15:0] tbm;

  sqw_chan i_sqw_chan (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .tog_o   (tog_o),
    .flag_o  (flag_o)
  );

  always #5 clk = ~clk;

  always @(negedge clk) tick_i <= div2 ? ~tick_i : 1'b1;

  // bench model of the timebase (R2)
  always @(posedge clk or negedge rst_n)
    if (!rst_n)      tbm <= 16'd0;
    else if (tick_i) tbm <= tbm + 16'd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_CYCLES && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic prog(input logic [7:0] lo, input logic [7:0] hp, input logic [7:0] ctrl);
    wr(2'd0, 8'h00);
    wr(2'd1, lo);
    wr(2'd2, hp);
    wr(2'd0, ctrl);
  endtask

  task automatic wait_tog(input int limit, output bit seen, output int at);
    logic p;
    p = tog_o;
    seen = 1'b0;
    at = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (tog_o != p) begin
        seen = 1'b1;
        at = cyc;
        return;
      end
    end
  endtask

  // first flip phase (R3) then n intervals (R4/R5)
  task automatic run_intervals(input logic [7:0] lo, input logic [7:0] hp, input int mult, input int n);
    bit seen;
    int at, last, hv;
    hv = (hp == 8'h00) ? 256 : int'(hp);
    wait_tog(300 * mult, seen, at);
    chk("R4 first flip seen", int'(seen), 1);
    chk("R3 flip phase", int'(8'(tbm - 16'd1)), int'(lo));
    last = at;
    for (int k = 0; k < n; k++) begin
      wait_tog(300 * mult, seen, at);
      if (hp == 8'h00) chk("R5 interval for 0x00", at - last, hv * mult);
      else             chk("R4 interval", at - last, hv * mult);
      last = at;
    end
  endtask

  initial begin
    bit seen;
    int at, first;
    logic [15:0] tgt;

    repeat (3) @(negedge clk);
    chk("R1 tog at reset", int'(tog_o), 0);
    chk("R1 flag at reset", int'(flag_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: half-period sweep
    for (int v = 0; v < NVEC; v++) begin
      prog(VECS[v].lo, VECS[v].half, 8'h07);
      run_intervals(VECS[v].lo, VECS[v].half, 1, 3);
    end

    // R2: tick on alternate cycles doubles the interval
    div2 = 1'b1;
    prog(8'h40, 8'h06, 8'h07);
    run_intervals(8'h40, 8'h06, 2, 2);
    div2 = 1'b0;
    @(negedge clk);

    // R6: dropping pwm_en holds level and compare byte
    prog(8'h20, 8'h05, 8'h07);
    wait_tog(300, seen, at);
    wait_tog(300, seen, at);
    chk("R4 flip before disable", int'(seen), 1);
    wr(2'd0, 8'h03);
    wait_tog(600, seen, at);
    chk("R6 no flip with mode off", int'(seen), 0);
    wr(2'd0, 8'h07);
    wait_tog(300, seen, at);
    chk("R6 resumes at held compare", int'(8'(tbm - 16'd1)), 8'h2A);

    // R7: compare write alone disarms; half write re-arms
    wr(2'd1, 8'h80);
    wait_tog(600, seen, at);
    chk("R7 disarmed after compare write", int'(seen), 0);
    wr(2'd2, 8'h05);
    run_intervals(8'h80, 8'h05, 1, 1);

    // R10: address 3 write has no effect
    wr(2'd3, 8'hFF);
    wait_tog(300, seen, first);
    wait_tog(300, seen, at);
    chk("R10 addr3 ignored interval", at - first, 5);

    // R8/R9: flag on 16-bit match, sticky
    tgt = tbm + 16'd300;
    prog(tgt[7:0], tgt[15:8], 8'h09);
    first = -1;
    while (tbm != tgt + 16'd8) begin
      @(negedge clk);
      if (flag_o && first < 0) first = int'(tbm);
    end
    chk("R8 flag set after 16-bit match", first, int'(tgt + 16'd1));
    repeat (50) @(negedge clk);
    chk("R9 flag sticky", int'(flag_o), 1);
    wr(2'd0, 8'h19);
    chk("R9 writing bit4=1 keeps flag", int'(flag_o), 1);
    wr(2'd0, 8'h09);
    chk("R9 writing bit4=0 clears flag", int'(flag_o), 0);

    // R8: no flag with mat_en clear
    tgt = tbm + 16'd300;
    prog(tgt[7:0], tgt[15:8], 8'h01);
    first = 0;
    while (tbm != tgt + 16'd8) begin
      @(negedge clk);
      if (flag_o) first = 1;
    end
    chk("R8 no flag without mat_en", first, 0);

    // R1: reset mid-run
    prog(8'h00, 8'h01, 8'h07);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 tog cleared by reset", int'(tog_o), 0);
    chk("R1 flag cleared by reset", int'(flag_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule